// File: doc/BRIEF.md
# Serial Receiver with Selectable Error Interrupt Routing

This block turns an asynchronous serial line into characters. An external rate generator supplies a one-cycle `bit_tick` at sixteen times the bit rate. The receiver synchronises the line and waits for a falling edge. It confirms the start bit at its centre, then samples every data, parity and stop bit at its own centre. Each character goes into a one-deep receive buffer.

A static configuration word sets:
- the character length (7 or 8 bits);
- the parity mode (none, forced zero, odd or even);
- whether receive faults are reported on the normal receive interrupt or on a separate error interrupt.

Parity, framing and overrun faults accumulate in a three-bit sticky status word. Reading that word clears it. Reading the data buffer marks it empty.

The block is meant to sit behind a register bus that turns register reads into the `rd_data` and `rd_status` strobes. It needs nothing else besides the tick source.

Top module: `serial_rx_core`

## Requirements
- R1: `cfg_word` fields: bit 0 clock enable, bit 1 receive enable, bits 3:2 parity mode (00 none, 01 zero, 10 odd, 11 even), bit 4 length (1 = 8 data bits, 0 = 7), bit 5 error routing.
- R2: Frames are received only while the clock enable and the receive enable are both 1. Otherwise the buffer, the status and both interrupts stay unchanged.
- R3: Each bit lasts 16 ticks and is sampled at its centre, data least significant bit first. A start bit that is no longer low 8 ticks after the falling edge is discarded without any effect.
- R4: In 8-bit mode `rx_data` holds all eight received bits. In 7-bit mode it holds the seven bits with bit 7 reading 0.
- R5: Status bit 2 (parity fault) is set when odd mode sees an even count of ones over data plus parity bit, when even mode sees an odd count, or when zero mode receives a parity bit of 1. It is never set with parity off.
- R6: Status bit 1 (framing fault) is set when the first stop bit samples low. Only one stop bit is examined.
- R7: Status bit 0 (overrun) is set when a character completes while the buffer still holds an unread one. The new character replaces the old.
- R8: Status bits stay set until a `rd_status` strobe clears them. A fault arriving in the same cycle as the strobe survives.
- R9: Each received character gives exactly one single-cycle interrupt pulse, one clock after the stop-bit sample. `irq_rx` and `irq_err` are never high together.
- R10: For a character with any fault, routing bit 1 sends the pulse to `irq_rx` and routing bit 0 sends it to `irq_err`. A fault-free character always pulses `irq_rx`.
- R11: A `rd_data` strobe empties the buffer, so the next character causes no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 6 | Static configuration (fields in R1) |
| bit_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rd_data | input | 1 | Strobe: buffer has been read |
| rd_status | input | 1 | Strobe: status has been read (clears it) |
| rx_data | output | 8 | Receive buffer |
| status | output | 3 | Sticky faults {parity, framing, overrun} |
| irq_rx | output | 1 | Receive interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |

## Verification
The bench uses the following cases to expose specific defects:

- **Start-bit glitch shorter than half a bit.** A design that skipped the mid-start recheck would clock in a phantom character and raise an interrupt.
- **Forced-zero parity carrying a 1.** A receiver that treated this mode as odd or even parity would miss the fault for some data values.
- **Bad stop bit.** The line stays low into the next idle period. A receiver that re-triggered badly would report a second frame.
- **Back-to-back characters without a buffer read.** These must raise overrun and keep the newer character.
- **Disabled receiver, and both routing settings on faulty characters.** Leaking gating or a swapped routing polarity would show up as interrupts on the wrong line.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int CHAR_W = 8;
  localparam int CFG_W  = 6;
  localparam int STAT_W = 3;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_e;

  // Field order mirrors cfg_word bits 5..0
  typedef struct packed {
    logic      err_to_rx;
    logic      len8;
    par_mode_e par;
    logic      rx_en;
    logic      clk_en;
  } cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  function automatic cfg_t decode_cfg(input logic [CFG_W-1:0] w);
    return cfg_t'(w);
  endfunction

  // Shift register fills from the top; a 7-bit character sits in [7:1]
  function automatic logic [CHAR_W-1:0] align_char(input logic [CHAR_W-1:0] sh,
                                                   input logic len8);
    return len8 ? sh : {1'b0, sh[CHAR_W-1:1]};
  endfunction

  function automatic logic parity_fault(input par_mode_e m,
                                        input logic [CHAR_W-1:0] ch,
                                        input logic pbit);
    logic ones_odd;
    ones_odd = ^{ch, pbit};
    case (m)
      PAR_ZERO: return pbit;
      PAR_ODD:  return !ones_odd;
      PAR_EVEN: return ones_odd;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              rxd_s,
  input  logic              len8,
  input  par_mode_e         par,
  output logic              done,
  output logic [CHAR_W-1:0] ch,
  output logic              pe,
  output logic              fe
);
  localparam int CNT_W = $clog2(TICKS_PER_BIT);
  localparam int IDX_W = $clog2(CHAR_W);
  localparam logic [CNT_W-1:0] MID_C  = CNT_W'(TICKS_PER_BIT/2 - 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(TICKS_PER_BIT - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [CHAR_W-1:0] sh;
  logic              pe_q;
  logic [IDX_W-1:0]  last_idx;
  logic              at_last;

  assign last_idx = len8 ? IDX_W'(CHAR_W-1) : IDX_W'(CHAR_W-2);
  assign at_last  = (cnt == LAST_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
      sh    <= '0;
      pe_q  <= 1'b0;
    end else if (!en) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          if (!rxd_s) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (cnt == MID_C) begin
            cnt <= '0;
            if (!rxd_s) begin
              state <= ST_DATA;
              idx   <= '0;
              pe_q  <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (at_last) begin
            cnt <= '0;
            sh  <= {rxd_s, sh[CHAR_W-1:1]};
            idx <= idx + 1'b1;
            if (idx == last_idx)
              state <= (par == PAR_NONE) ? ST_STOP : ST_PAR;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (at_last) begin
            cnt   <= '0;
            pe_q  <= parity_fault(par, align_char(sh, len8), rxd_s);
            state <= ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (at_last) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done = en && tick && (state == ST_STOP) && at_last;
  assign ch   = align_char(sh, len8);
  assign pe   = pe_q;
  assign fe   = !rxd_s;
endmodule

// File: rtl/srx_flags.sv
module srx_flags
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [CHAR_W-1:0] ch,
  input  logic              pe,
  input  logic              fe,
  input  logic              route_to_rx,
  input  logic              rd_data,
  input  logic              rd_status,
  output logic [CHAR_W-1:0] data_q,
  output logic [STAT_W-1:0] status_q,
  output logic              full_q,
  output logic              irq_rx_q,
  output logic              irq_err_q
);
  logic              ove_now;
  logic [STAT_W-1:0] new_err;
  logic              any_err;

  assign ove_now = done && full_q && !rd_data;
  assign new_err = done ? {pe, fe, ove_now} : '0;
  assign any_err = |new_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q    <= '0;
      status_q  <= '0;
      full_q    <= 1'b0;
      irq_rx_q  <= 1'b0;
      irq_err_q <= 1'b0;
    end else begin
      if (done) data_q <= ch;
      if (done)         full_q <= 1'b1;
      else if (rd_data) full_q <= 1'b0;
      status_q  <= (rd_status ? '0 : status_q) | new_err;
      irq_rx_q  <= done && (route_to_rx || !any_err);
      irq_err_q <= done && !route_to_rx && any_err;
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              bit_tick,
  input  logic              rxd,
  input  logic              rd_data,
  input  logic              rd_status,
  output logic [CHAR_W-1:0] rx_data,
  output logic [STAT_W-1:0] status,
  output logic              irq_rx,
  output logic              irq_err
);
  cfg_t              cfg;
  logic              line_en;
  logic              rxd_s;
  logic              frame_done;
  logic [CHAR_W-1:0] frame_char;
  logic              frame_pe;
  logic              frame_fe;
  logic              rx_full;

  assign cfg     = decode_cfg(cfg_word);
  assign line_en = cfg.clk_en && cfg.rx_en;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rxd),
    .d_sync  (rxd_s)
  );

  srx_frame #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_frame (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (line_en),
    .tick  (bit_tick),
    .rxd_s (rxd_s),
    .len8  (cfg.len8),
    .par   (cfg.par),
    .done  (frame_done),
    .ch    (frame_char),
    .pe    (frame_pe),
    .fe    (frame_fe)
  );

  srx_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (frame_done),
    .ch          (frame_char),
    .pe          (frame_pe),
    .fe          (frame_fe),
    .route_to_rx (cfg.err_to_rx),
    .rd_data     (rd_data),
    .rd_status   (rd_status),
    .data_q      (rx_data),
    .status_q    (status),
    .full_q      (rx_full),
    .irq_rx_q    (irq_rx),
    .irq_err_q   (irq_err)
  );
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] cfg_word,
  input logic       rd_data,
  input logic       rd_status,
  input logic       frame_done,
  input logic       rx_full,
  input logic [2:0] status,
  input logic       irq_rx,
  input logic       irq_err
);
  // R9
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_rx && irq_err));

  // R10
  err_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (!cfg_word[5] && status != 3'b000));

  // R2
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_word[0] && cfg_word[1]) |=> (!irq_rx && !irq_err));

  // R7
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_full && !rd_data) |=> status[0]);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_status |=> ((status & $past(status)) == $past(status)));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !frame_done) |=> (status == 3'b000));

  // R11
  full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rx_full);

  // R9
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (irq_rx || irq_err));
endmodule

bind serial_rx_core serial_rx_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_word   (cfg_word),
  .rd_data    (rd_data),
  .rd_status  (rd_status),
  .frame_done (frame_done),
  .rx_full    (rx_full),
  .status     (status),
  .irq_rx     (irq_rx),
  .irq_err    (irq_err)
);

// File: tb/serial_rx_core_bench.sv
module serial_rx_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cfg_word = 6'b000011;
  logic       rxd = 1'b1;
  logic       rd_data = 1'b0;
  logic       rd_status = 1'b0;
  logic [7:0] rx_data;
  logic [2:0] status;
  logic       irq_rx;
  logic       irq_err;
  logic [1:0] tcnt = 2'd0;
  logic       bit_tick;

  int vectors = 0;
  int misses = 0;
  int n_rx = 0;
  int n_err = 0;
  int cycles = 0;
  bit prev_unread = 1'b0;
  logic [7:0] last_data = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) tcnt <= tcnt + 2'd1;
  assign bit_tick = (tcnt == 2'd3);

  serial_rx_core u_serial_rx_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_word  (cfg_word),
    .bit_tick  (bit_tick),
    .rxd       (rxd),
    .rd_data   (rd_data),
    .rd_status (rd_status),
    .rx_data   (rx_data),
    .status    (status),
    .irq_rx    (irq_rx),
    .irq_err   (irq_err)
  );

  always @(negedge clk) begin
    if (irq_rx)  n_rx++;
    if (irq_err) n_err++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      misses++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  // R1 field layout: {route, len8, par[1:0], rx_en, clk_en}
  function automatic logic [5:0] mk_cfg(input logic [1:0] par, input logic len8,
                                        input logic route);
    return {route, len8, par, 1'b1, 1'b1};
  endfunction

  function automatic logic par_bit(input logic [1:0] par, input logic [7:0] d);
    case (par)
      2'b01:   return 1'b0;
      2'b10:   return ~(^d);
      2'b11:   return ^d;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] exp_char(input logic [7:0] d, input logic len8);
    return len8 ? d : {1'b0, d[6:0]};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v, input int ticks = 16);
    rxd = v;
    for (int i = 0; i < ticks; ) begin
      @(posedge clk);
      if (bit_tick) i++;
    end
    @(negedge clk);
  endtask

  task automatic pulse(input bit which);
    @(negedge clk);
    if (which) rd_status = 1'b1; else rd_data = 1'b1;
    @(negedge clk);
    rd_status = 1'b0;
    rd_data = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [5:0] c,
                            input bit badpar, input bit badstop);
    logic [7:0] m;
    m = exp_char(d, c[4]);
    drive_bit(1'b0);
    for (int i = 0; i < (c[4] ? 8 : 7); i++) drive_bit(m[i]);
    if (c[3:2] != 2'b00) drive_bit(par_bit(c[3:2], m) ^ badpar);
    drive_bit(!badstop);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  // Sends one frame on an enabled receiver and checks every observable result
  task automatic frame_and_check(input logic [7:0] d, input logic [1:0] par,
                                 input logic len8, input logic route,
                                 input bit badpar, input bit badstop);
    int rx0, er0;
    logic [2:0] es;
    bit anyerr;
    cfg_word = mk_cfg(par, len8, route);
    rx0 = n_rx;
    er0 = n_err;
    send_frame(d, cfg_word, badpar, badstop);
    es = {(par != 2'b00) && badpar, badstop, prev_unread};
    anyerr = (es != 3'b000);
    check("R4 data", int'(rx_data), int'(exp_char(d, len8)));
    check("R5/R6/R7 status", int'(status), int'(es));
    check("R9/R10 irq_rx count", n_rx - rx0, (!anyerr || route) ? 1 : 0);
    check("R10 irq_err count", n_err - er0, (anyerr && !route) ? 1 : 0);
    prev_unread = 1'b1;
    last_data = exp_char(d, len8);
  endtask

  initial begin
    int rx0, er0;
    void'($urandom(32'h5EED_0A11));
    repeat (5) @(negedge clk);
    // reset state
    check("R8 reset status", int'(status), 0);
    check("R4 reset data", int'(rx_data), 0);
    check("R9 reset irq", int'({irq_rx, irq_err}), 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // R3 R9 plain 8-bit no parity
    frame_and_check(8'hA5, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    // R7 second character without a read: overrun, newer data kept
    frame_and_check(8'h3C, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
    pulse(1'b1);
    check("R8 cleared after read", int'(status), 0);
    pulse(1'b0);
    prev_unread = 1'b0;

    // R2 receive enable clear, then clock enable clear
    for (int k = 0; k < 2; k++) begin
      cfg_word = (k == 0) ? 6'b010001 : 6'b010010;
      rx0 = n_rx;
      er0 = n_err;
      send_frame(8'h00, cfg_word, 1'b0, 1'b1);
      check("R2 data untouched", int'(rx_data), int'(last_data));
      check("R2 status untouched", int'(status), 0);
      check("R2 no irq", (n_rx - rx0) + (n_err - er0), 0);
    end

    // R3 short start glitch is discarded
    cfg_word = mk_cfg(2'b00, 1'b1, 1'b0);
    rx0 = n_rx;
    er0 = n_err;
    drive_bit(1'b0, 4);
    drive_bit(1'b1, 40);
    check("R3 glitch no irq", (n_rx - rx0) + (n_err - er0), 0);
    check("R3 glitch data kept", int'(rx_data), int'(last_data));

    // R5 zero parity with parity bit 1, routed to error interrupt
    frame_and_check(8'h00, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0);
    // R8 remains set without a status read
    drive_bit(1'b1, 48);
    check("R8 sticky", int'(status), 3'b100);
    pulse(1'b1);
    check("R8 clear on read", int'(status), 0);
    // R11 after a data read the next frame has no overrun
    pulse(1'b0);
    prev_unread = 1'b0;
    // R6 R10 bad stop routed to receive interrupt, 7-bit even parity
    frame_and_check(8'hFF, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1);
    pulse(1'b1);

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      logic [1:0] par;
      logic len8, route;
      bit bp, bs, rd;
      d = 8'($urandom);
      par = 2'($urandom);
      len8 = 1'($urandom);
      route = 1'($urandom);
      bp = ($urandom % 4) == 0;
      bs = ($urandom % 5) == 0;
      rd = 1'($urandom);
      frame_and_check(d, par, len8, route, bp, bs);
      pulse(1'b1);
      if (rd) begin
        pulse(1'b0);
        prev_unread = 1'b0;
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule